// File: doc/BRIEF.md
# Decimal Adder/Subtracter for Packed BCD Words

This block is a purely combinational arithmetic unit. It takes two unsigned decimal words, each made of `DIGITS` packed 8-4-2-1 digits, and either adds them or subtracts the second from the first. The choice is made by a single operation select. The answer always comes out as an unsigned decimal magnitude. Two flags qualify it: a carry-out flag for an addition that does not fit, and a negative flag for a subtraction whose true difference is below or equal to zero.

Inside, each decade is a 4-bit binary adder followed by a correction step, and the decades ripple from the least to the most significant. Subtraction adds the nine's complement of the subtrahend. The carry out of the top decade is then applied to the bottom decade in a separate increment pass, which stands in for a feedback path. When that carry is absent, the word is still in nine's complement form, so each digit is complemented again to recover the magnitude.

The unit sits inside a larger datapath and is used wherever decimal words are combined. Its outputs follow its inputs within the same cycle.

Top module: `bcd_addsub`

## Requirements
- R1: Digit i of every word occupies bits 4i+3 down to 4i, with digit 0 the least significant. Each digit is coded 8-4-2-1 with values 0 to 9. For valid operands, every result digit is in the range 0 to 9.
- R2: With `sub_sel` = 0 (add), `result` equals (A + B) modulo 10^DIGITS.
- R3: In add mode, `overflow` is 1 exactly when A + B is at least 10^DIGITS, and `underflow` is 0.
- R4: With `sub_sel` = 1 (subtract) and A > B, `result` equals A − B and `underflow` is 0. The end-around increment never produces a second carry.
- R5: In subtract mode with A ≤ B, `underflow` is 1 and `result` equals B − A. For A = B the magnitude is zero and `underflow` is still 1.
- R6: In subtract mode, `overflow` is 0.
- R7: A decade whose raw sum is 10 to 19 yields its sum minus 10 and passes a carry into the next decade, so that a carry can travel through every decade (for example 99..9 + 1 gives 0 with `overflow` 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 4*DIGITS | Operand A, packed BCD, minuend in subtract mode |
| opb | input | 4*DIGITS | Operand B, packed BCD, subtrahend in subtract mode |
| sub_sel | input | 1 | 0 selects A + B, 1 selects A − B |
| result | output | 4*DIGITS | Unsigned BCD magnitude of the answer |
| overflow | output | 1 | Add mode only: the sum did not fit in DIGITS digits |
| underflow | output | 1 | Subtract mode only: A ≤ B, so the result is the magnitude of a non-positive difference |

## Verification
The bench aims at the places where decimal arithmetic goes wrong. A full-length carry chain (99..9 + 1, 99..9 + 99..9) catches a design that skips the +6 correction: it would leave codes 1010 to 1111 in the result, or it would drop the ripple partway up the word. Subtracting equal operands, zero minus all nines and all nines minus zero test the end-around carry. A design that fed the carry in at the wrong decade, or that did not complement back a negative result, would show nine's complement digits or be off by one. Random operands in both modes expose a flag that leaks into the wrong mode.

// File: rtl/bcd_arith_pkg.sv
`timescale 1ns/1ps
package bcd_arith_pkg;

    // One decimal digit, 8-4-2-1 coded
    typedef logic [3:0] digit_t;

    // Output of one corrected decade
    typedef struct packed {
        logic   carry;
        digit_t digit;
    } dec_sum_t;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    localparam digit_t DIGIT_MAX = 4'd9;

    // 9 minus the digit
    function automatic digit_t nines_of(digit_t d);
        return DIGIT_MAX - d;
    endfunction

    // Turn a 5-bit binary decade sum (0..19) into a decimal digit and a carry
    function automatic dec_sum_t dec_correct(logic [4:0] raw);
        dec_sum_t r;
        if (raw > 5'd9) begin
            r.carry = 1'b1;
            r.digit = raw[3:0] + 4'd6;
        end else begin
            r.carry = 1'b0;
            r.digit = raw[3:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/bcd_decade.sv
`timescale 1ns/1ps
module bcd_decade
    import bcd_arith_pkg::*;
(
    input  digit_t   a,
    input  digit_t   b,
    input  logic     cin,
    output dec_sum_t sum
);
    logic [4:0] bin_sum;

    always_comb begin
        bin_sum = {1'b0, a} + {1'b0, b} + {4'b0000, cin};
        sum     = dec_correct(bin_sum);
    end
endmodule

// File: rtl/bcd_ripple.sv
`timescale 1ns/1ps
module bcd_ripple
    import bcd_arith_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input  logic [W-1:0] a_vec,
    input  logic [W-1:0] b_vec,
    input  logic         cin,
    output logic [W-1:0] sum_vec,
    output logic         cout
);
    logic [DIGITS:0] chain;

    assign chain[0] = cin;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dec
        dec_sum_t s;
        bcd_decade u_dec (
            .a   (a_vec[4*g +: 4]),
            .b   (b_vec[4*g +: 4]),
            .cin (chain[g]),
            .sum (s)
        );
        assign sum_vec[4*g +: 4] = s.digit;
        assign chain[g+1]        = s.carry;
    end

    assign cout = chain[DIGITS];
endmodule

// File: rtl/bcd_inc.sv
`timescale 1ns/1ps
module bcd_inc
    import bcd_arith_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input  logic [W-1:0] din,
    input  logic         inc,
    output logic [W-1:0] dout,
    output logic         cout
);
    logic [DIGITS:0] chain;

    assign chain[0] = inc;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        digit_t d;
        assign d = din[4*g +: 4];
        always_comb begin
            if (chain[g] && (d == DIGIT_MAX)) begin
                dout[4*g +: 4] = 4'd0;
                chain[g+1]     = 1'b1;
            end else begin
                dout[4*g +: 4] = d + {3'b000, chain[g]};
                chain[g+1]     = 1'b0;
            end
        end
    end

    assign cout = chain[DIGITS];
endmodule

// File: rtl/bcd_nines_mask.sv
`timescale 1ns/1ps
module bcd_nines_mask
    import bcd_arith_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input  logic [W-1:0] din,
    input  logic         en,
    output logic [W-1:0] dout
);
    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        assign dout[4*g +: 4] = en ? nines_of(din[4*g +: 4]) : din[4*g +: 4];
    end
endmodule

// File: rtl/bcd_addsub.sv
`timescale 1ns/1ps
module bcd_addsub
    import bcd_arith_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         sub_sel,
    output logic [W-1:0] result,
    output logic         overflow,
    output logic         underflow
);
    op_e          op;
    logic         is_sub;
    logic [W-1:0] b_eff;
    logic [W-1:0] raw_sum;
    logic         raw_cout;
    logic         eac;
    logic [W-1:0] inc_sum;
    logic         inc_cout;
    logic [W-1:0] neg_mag;

    assign op     = op_e'(sub_sel);
    assign is_sub = (op == OP_SUB);

    // Subtrahend goes through a nine's complementer in subtract mode
    bcd_nines_mask #(.DIGITS(DIGITS)) u_bcomp (
        .din  (opb),
        .en   (is_sub),
        .dout (b_eff)
    );

    // First pass: carry-in tied low, so no loop exists
    bcd_ripple #(.DIGITS(DIGITS)) u_main (
        .a_vec   (opa),
        .b_vec   (b_eff),
        .cin     (1'b0),
        .sum_vec (raw_sum),
        .cout    (raw_cout)
    );

    // Second pass: end-around carry applied as a decimal increment
    assign eac = is_sub & raw_cout;

    bcd_inc #(.DIGITS(DIGITS)) u_eac (
        .din  (raw_sum),
        .inc  (eac),
        .dout (inc_sum),
        .cout (inc_cout)
    );

    // Negative difference: undo the nine's complement digit by digit
    bcd_nines_mask #(.DIGITS(DIGITS)) u_rcomp (
        .din  (raw_sum),
        .en   (is_sub & ~raw_cout),
        .dout (neg_mag)
    );

    always_comb begin
        unique case (op)
            OP_ADD: begin
                result    = raw_sum;
                overflow  = raw_cout;
                underflow = 1'b0;
            end
            OP_SUB: begin
                result    = raw_cout ? inc_sum : neg_mag;
                overflow  = 1'b0;
                underflow = ~raw_cout;
            end
            default: begin
                result    = raw_sum;
                overflow  = 1'b0;
                underflow = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bcd_addsub_chk.sv
`timescale 1ns/1ps
module bcd_addsub_chk #(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic         sub_sel,
    input logic [W-1:0] result,
    input logic         overflow,
    input logic         underflow,
    input logic         raw_cout,
    input logic         inc_cout
);
    function automatic logic word_ok(logic [W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < DIGITS; i++)
            if (v[4*i +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    logic ops_ok;
    assign ops_ok = word_ok(opa) && word_ok(opb);

    always_comb begin
        // R1: legal digits out for legal digits in
        a_r1_digits_valid: assert (!ops_ok || word_ok(result))
            else $error("R1: result holds a non-decimal digit");
        // R3: no negative flag while adding
        a_r3_no_underflow_in_add: assert (sub_sel || !underflow)
            else $error("R3: underflow raised in add mode");
        // R6: no carry-out flag while subtracting
        a_r6_no_overflow_in_sub: assert (!sub_sel || !overflow)
            else $error("R6: overflow raised in subtract mode");
        // R4: end-around increment never carries out again
        a_r4_eac_single_carry: assert (!(ops_ok && sub_sel && raw_cout) || !inc_cout)
            else $error("R4: end-around increment produced a carry");
        // R5: equal operands give zero magnitude flagged negative
        a_r5_equal_zero: assert (!(ops_ok && sub_sel && opa == opb) || (result == '0 && underflow))
            else $error("R5: equal operands did not give flagged zero");
        // R2: adding zero returns A unchanged without carry
        a_r2_add_zero: assert (!(ops_ok && !sub_sel && opb == '0) || (result == opa && !overflow))
            else $error("R2: adding zero changed the operand");
    end
endmodule

bind bcd_addsub bcd_addsub_chk #(.DIGITS(DIGITS)) u_chk (
    .opa       (opa),
    .opb       (opb),
    .sub_sel   (sub_sel),
    .result    (result),
    .overflow  (overflow),
    .underflow (underflow),
    .raw_cout  (raw_cout),
    .inc_cout  (inc_cout)
);

// File: tb/bcd_addsub_test.sv
`timescale 1ns/1ps
module bcd_addsub_test;
    localparam int DIGITS = 4;
    localparam int W      = 4 * DIGITS;
    localparam int MOD    = 10000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         sub_sel = 1'b0;
    logic [W-1:0] result;
    logic         overflow;
    logic         underflow;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    typedef struct {
        logic [W-1:0] res;
        logic         ovf;
        logic         udf;
        string        tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    bcd_addsub #(.DIGITS(DIGITS)) uut (
        .opa       (opa),
        .opb       (opb),
        .sub_sel   (sub_sel),
        .result    (result),
        .overflow  (overflow),
        .underflow (underflow)
    );

    function automatic logic [W-1:0] to_bcd(int v);
        logic [W-1:0] r;
        int x;
        x = v;
        for (int i = 0; i < DIGITS; i++) begin
            r[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    // Driver: applies operands and pushes the expected item
    task automatic drive(int a, int b, bit s, string tag);
        exp_t e;
        @(posedge clk);
        #1;
        opa     = to_bcd(a);
        opb     = to_bcd(b);
        sub_sel = s;
        if (!s) begin
            e.res = to_bcd((a + b) % MOD);
            e.ovf = (a + b) >= MOD;
            e.udf = 1'b0;
        end else if (a > b) begin
            e.res = to_bcd(a - b);
            e.ovf = 1'b0;
            e.udf = 1'b0;
        end else begin
            e.res = to_bcd(b - a);
            e.ovf = 1'b0;
            e.udf = 1'b1;
        end
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares away from the active edge
    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            exp_t e;
            bit   bad_digit;
            e = sb.pop_front();
            bad_digit = 1'b0;
            for (int i = 0; i < DIGITS; i++)
                if (result[4*i +: 4] > 4'd9) bad_digit = 1'b1;
            n_checks++;
            if (bad_digit) begin
                n_fails++;
                $display("FAIL R1 [%s] illegal digit: got %h expected %h", e.tag, result, e.res);
            end else if (result !== e.res || overflow !== e.ovf || underflow !== e.udf) begin
                n_fails++;
                $display("FAIL %s: got res=%h ovf=%b udf=%b expected res=%h ovf=%b udf=%b",
                         e.tag, result, overflow, underflow, e.res, e.ovf, e.udf);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #500000;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // Reset state: zero operands, add mode
        drive(0, 0, 1'b0, "R2 R3 idle zero");
        // R7: carry through every decade
        drive(9999, 1, 1'b0, "R7 full ripple");
        drive(9999, 9999, 1'b0, "R3 R7 max sum");
        drive(5000, 5000, 1'b0, "R3 exact modulus");
        drive(5, 5, 1'b0, "R7 single decade carry");
        drive(1234, 4321, 1'b0, "R2 no carry");
        drive(909, 91, 1'b0, "R7 mixed carries");
        // Subtract corners
        drive(0, 0, 1'b1, "R5 zero minus zero");
        drive(9999, 9999, 1'b1, "R5 equal all nines");
        drive(4711, 4711, 1'b1, "R5 equal operands");
        drive(9999, 0, 1'b1, "R4 R6 nines minus zero");
        drive(0, 9999, 1'b1, "R5 R6 zero minus nines");
        drive(1000, 1, 1'b1, "R4 borrow chain");
        drive(1, 1000, 1'b1, "R5 negative borrow chain");
        drive(1, 0, 1'b1, "R4 one minus zero");
        drive(0, 1, 1'b1, "R5 zero minus one");
        // Random operands in both modes
        for (int k = 0; k < 300; k++)
            drive($urandom_range(0, MOD - 1), $urandom_range(0, MOD - 1), 1'b0, "R1 R2 R3 random add");
        for (int k = 0; k < 300; k++)
            drive($urandom_range(0, MOD - 1), $urandom_range(0, MOD - 1), 1'b1, "R1 R4 R5 R6 random sub");
        wait (sb.size() == 0);
        @(posedge clk);
        finish_run();
    end
endmodule